// File: doc/BRIEF.md
# Program Counter with Conditional Load

This block holds the 16-bit instruction address of a byte-serial processor. Every byte cycle, marked by an advance strobe, the counter steps by one, and that includes the execute cycle of each instruction. During the execute cycle the counter may instead take the value held in a 16-bit preload register. That register is written one byte at a time from the data byte.

Whether the load happens depends on a 2-bit jump mode and on one of four flags, which a 2-bit selector picks. This gives an unconditional jump, no jump, a jump when the flag is set and a jump when the flag is clear. There is no separate branch path.

Because the counter advances again on the byte cycle after a load, software places the target minus one in the preload register. A second 16-bit register holds a temporary data address, also written byte by byte. An address-source bit picks which of the two registers drives the address output.

Top module: `pcSequencer`

## Requirements
- R1: While `rstN` is low, and after it is released with no further advance, the counter is 0x0000 and the temporary address register is 0x0000.
- R2: A cycle with `advance`=1 that does not load adds one to the counter, modulo 2^16, so 0xFFFF is followed by 0x0000.
- R3: A cycle with `advance`=0 leaves the counter and all registers unchanged.
- R4: `flagSel` picks the tested flag: 0 = `flagMinus`, 1 = `flagZero`, 2 = `aluCarry`, 3 = `storedCarry`.
- R5: In a cycle with `execute`=1 and `advance`=1, `jumpMode`=2'b00 always loads the preload value and 2'b11 never loads; `jumpMode[1]` is the upper mode bit.
- R6: In such a cycle, `jumpMode`=2'b01 loads when the selected flag is 1, and 2'b10 loads when it is 0; otherwise the counter increments.
- R7: With `execute`=0, the mode and flag inputs have no effect and the counter only increments.
- R8: A load replaces the increment for that cycle, so the next advance yields preload+1; software therefore writes target minus one.
- R9: `addrSrc`=1 drives `addr` from the counter; `addrSrc`=0 drives it from the temporary address register.
- R10: The byte writes `wrPreLo`/`wrPreHi`/`wrTmpLo`/`wrTmpHi` store `dataIn` into bits 7:0 or 15:8 only in a cycle with `execute`=1 and `advance`=1, and are ignored otherwise. A load in the same cycle as a preload write uses the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| advance | input | 1 | Byte-cycle strobe |
| execute | input | 1 | Marks the execute cycle of an instruction |
| dataIn | input | 8 | Byte for the register writes |
| wrPreLo | input | 1 | Write preload bits 7:0 |
| wrPreHi | input | 1 | Write preload bits 15:8 |
| wrTmpLo | input | 1 | Write temporary address bits 7:0 |
| wrTmpHi | input | 1 | Write temporary address bits 15:8 |
| flagMinus | input | 1 | Result sign flag |
| flagZero | input | 1 | Result zero flag |
| aluCarry | input | 1 | Live ALU carry-out |
| storedCarry | input | 1 | Registered carry |
| flagSel | input | 2 | Flag selector |
| jumpMode | input | 2 | Load mode |
| addrSrc | input | 1 | Address source select |
| addr | output | 16 | Address output |

## Verification
The hardest situation to reach is a conditional load, where the outcome depends at once on mode, selector and four flag levels. It also requires the preload register to hold a distinct, known value first. The bench sweeps all 256 combinations of mode, selector and flag vector. Before each one it writes a fresh preload value through two execute cycles with mode 11, so a wrong flag or a wrong mode shows up as a wrong address. Separate sequences drive the counter through 0xFFFF and pair a preload write with a load in the same cycle.

// File: rtl/pcSeqPkg.sv
package pcSeqPkg;
  localparam int ADDR_BYTES = 2;

  typedef struct packed {
    logic                  incPc;
    logic                  loadPc;
    logic [ADDR_BYTES-1:0] wrPre;
    logic [ADDR_BYTES-1:0] wrTmp;
  } ctrlStrobes_t;
endpackage

// File: rtl/pcControl.sv
module pcControl
  import pcSeqPkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  advance,
  input  logic                  execute,
  input  logic [ADDR_BYTES-1:0] wrPreReq,
  input  logic [ADDR_BYTES-1:0] wrTmpReq,
  input  logic [3:0]            flagVec,
  input  logic [1:0]            flagSel,
  input  logic [1:0]            jumpMode,
  output ctrlStrobes_t          strobes
);
  logic selFlag;
  logic [1:0] effMode;
  logic takeJump;
  logic commit;

  // flag order: 0 minus, 1 zero, 2 ALU carry, 3 stored carry
  assign selFlag = flagVec[flagSel];

  // outside execute the mode reads as "never"
  assign effMode = execute ? jumpMode : 2'b11;

  always_comb begin
    unique case (effMode)
      2'b00:   takeJump = 1'b1;
      2'b01:   takeJump = selFlag;
      2'b10:   takeJump = ~selFlag;
      default: takeJump = 1'b0;
    endcase
  end

  assign commit         = advance & execute;
  assign strobes.loadPc = advance & takeJump;
  assign strobes.incPc  = advance & ~takeJump;
  assign strobes.wrPre  = commit ? wrPreReq : '0;
  assign strobes.wrTmp  = commit ? wrTmpReq : '0;

  p_no_load_outside_exec_r7: assert property (@(posedge clk) disable iff (!rstN)
    !execute |-> !strobes.loadPc);
  p_mode_never_r5: assert property (@(posedge clk) disable iff (!rstN)
    (jumpMode == 2'b11) |-> !strobes.loadPc);
  p_mode_always_r5: assert property (@(posedge clk) disable iff (!rstN)
    (advance && execute && jumpMode == 2'b00) |-> strobes.loadPc);
  p_write_gated_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(advance && execute) |-> (strobes.wrPre == '0 && strobes.wrTmp == '0));
endmodule

// File: rtl/pcDatapath.sv
module pcDatapath
  import pcSeqPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [BYTE_W-1:0] dataIn,
  input  logic              addrSrc,
  output logic [ADDR_W-1:0] addr
);
  localparam int NB = ADDR_W / BYTE_W;

  logic [ADDR_W-1:0] pcReg;
  logic [ADDR_W-1:0] preloadReg;
  logic [ADDR_W-1:0] tmpReg;

  always_ff @(posedge clk) begin
    if (!rstN)               pcReg <= '0;
    else if (strobes.loadPc) pcReg <= preloadReg;
    else if (strobes.incPc)  pcReg <= pcReg + 1'b1;
  end

  for (genvar b = 0; b < NB; b++) begin : g_byte
    always_ff @(posedge clk) begin
      if (!rstN) begin
        preloadReg[b*BYTE_W +: BYTE_W] <= '0;
        tmpReg[b*BYTE_W +: BYTE_W]     <= '0;
      end else begin
        if (strobes.wrPre[b]) preloadReg[b*BYTE_W +: BYTE_W] <= dataIn;
        if (strobes.wrTmp[b]) tmpReg[b*BYTE_W +: BYTE_W]     <= dataIn;
      end
    end
  end

  assign addr = addrSrc ? pcReg : tmpReg;

  p_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.incPc && !strobes.loadPc) |=> $stable(pcReg));
  p_inc_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.incPc |=> pcReg == $past(pcReg) + 1'b1);
  p_load_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadPc |=> pcReg == $past(preloadReg));
  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strobes.incPc, strobes.loadPc}) <= 1);
endmodule

// File: rtl/pcSequencer.sv
module pcSequencer
  import pcSeqPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              advance,
  input  logic              execute,
  input  logic [BYTE_W-1:0] dataIn,
  input  logic              wrPreLo,
  input  logic              wrPreHi,
  input  logic              wrTmpLo,
  input  logic              wrTmpHi,
  input  logic              flagMinus,
  input  logic              flagZero,
  input  logic              aluCarry,
  input  logic              storedCarry,
  input  logic [1:0]        flagSel,
  input  logic [1:0]        jumpMode,
  input  logic              addrSrc,
  output logic [ADDR_W-1:0] addr
);
  ctrlStrobes_t strobes;

  pcControl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .advance  (advance),
    .execute  (execute),
    .wrPreReq ({wrPreHi, wrPreLo}),
    .wrTmpReq ({wrTmpHi, wrTmpLo}),
    .flagVec  ({storedCarry, aluCarry, flagZero, flagMinus}),
    .flagSel  (flagSel),
    .jumpMode (jumpMode),
    .strobes  (strobes)
  );

  pcDatapath #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .dataIn  (dataIn),
    .addrSrc (addrSrc),
    .addr    (addr)
  );
endmodule

// File: tb/pcSequencer_tb.sv
module pcSequencer_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic advance = 0, execute = 0;
  logic [7:0] dataIn = 0;
  logic wrPreLo = 0, wrPreHi = 0, wrTmpLo = 0, wrTmpHi = 0;
  logic flagMinus = 0, flagZero = 0, aluCarry = 0, storedCarry = 0;
  logic [1:0] flagSel = 0, jumpMode = 2'b11;
  logic addrSrc = 1;
  logic [15:0] addr;

  int checks = 0, fails = 0;
  logic [15:0] expPc = 0, expPre = 0, expTmp = 0;

  always #2 clk = ~clk;

  pcSequencer u_dut (
    .clk(clk), .rstN(rstN), .advance(advance), .execute(execute), .dataIn(dataIn),
    .wrPreLo(wrPreLo), .wrPreHi(wrPreHi), .wrTmpLo(wrTmpLo), .wrTmpHi(wrTmpHi),
    .flagMinus(flagMinus), .flagZero(flagZero), .aluCarry(aluCarry),
    .storedCarry(storedCarry), .flagSel(flagSel), .jumpMode(jumpMode),
    .addrSrc(addrSrc), .addr(addr));

  task automatic check(input string req, input logic [15:0] exp);
    checks++;
    if (addr !== exp) begin
      fails++;
      $display("FAIL %s: addr=%h expected=%h", req, addr, exp);
    end
  endtask

  // one byte cycle; model is built from the requirement text
  task automatic step(input string req, input logic adv, input logic exe,
                      input logic [3:0] wr, input logic [7:0] d,
                      input logic [1:0] sel, input logic [1:0] mode,
                      input logic [3:0] flags, input logic src);
    logic f, take;
    @(negedge clk);
    advance = adv; execute = exe; {wrTmpHi, wrTmpLo, wrPreHi, wrPreLo} = wr;
    dataIn = d; flagSel = sel; jumpMode = mode;
    {storedCarry, aluCarry, flagZero, flagMinus} = flags; addrSrc = src;
    f = flags[sel];
    take = adv && exe && (mode == 2'b00 || (mode == 2'b01 && f) || (mode == 2'b10 && !f));
    @(posedge clk);
    if (take) expPc = expPre;
    else if (adv) expPc = expPc + 16'd1;
    if (adv && exe) begin
      if (wr[0]) expPre[7:0] = d;
      if (wr[1]) expPre[15:8] = d;
      if (wr[2]) expTmp[7:0] = d;
      if (wr[3]) expTmp[15:8] = d;
    end
    #1 check(req, src ? expPc : expTmp);
  endtask

  task automatic setPre(input logic [15:0] v);
    step("R10", 1, 1, 4'b0001, v[7:0], 0, 2'b11, 0, 1);
    step("R10", 1, 1, 4'b0010, v[15:8], 0, 2'b11, 0, 1);
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog: addr=%h expected=finish", addr);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R1", 16'h0000);
    @(negedge clk) rstN = 1;
    @(posedge clk); #1 check("R1", 16'h0000);
    addrSrc = 0; #1 check("R1", 16'h0000);
    addrSrc = 1;

    // R2 plain counting, R3 hold
    for (int i = 0; i < 5; i++) step("R2", 1, 0, 0, 0, 0, 2'b11, 0, 1);
    for (int i = 0; i < 3; i++) step("R3", 0, 1, 4'b1111, 8'hA5, 0, 2'b00, 0, 1);

    // R7: modes ignored outside execute
    for (int m = 0; m < 4; m++)
      step("R7", 1, 0, 4'b0011, 8'h77, 0, m[1:0], 4'hF, 1);

    // R4/R5/R6 sweep over all modes, selectors and flag vectors
    for (int m = 0; m < 4; m++)
      for (int s = 0; s < 4; s++)
        for (int fv = 0; fv < 16; fv++) begin
          setPre(16'h1000 + 16'(m * 64 + s * 16 + fv) * 16'd37);
          step(m == 0 || m == 3 ? "R5" : (fv[0] ? "R4" : "R6"),
               1, 1, 0, 0, s[1:0], m[1:0], fv[3:0], 1);
          step("R8", 1, 0, 0, 0, 0, 2'b11, 0, 1);
        end

    // R2 wrap through 0xFFFF via load of 0xFFFE
    setPre(16'hFFFE);
    step("R5", 1, 1, 0, 0, 0, 2'b00, 0, 1);
    step("R2", 1, 0, 0, 0, 0, 2'b11, 0, 1);
    step("R2", 1, 0, 0, 0, 0, 2'b11, 0, 1);
    check("R2", 16'h0000);

    // R10: writes outside execute ignored; jump proves old preload
    setPre(16'h2345);
    step("R10", 1, 0, 4'b0011, 8'hEE, 0, 2'b11, 0, 1);
    step("R10", 0, 1, 4'b0011, 8'hDD, 0, 2'b11, 0, 1);
    step("R10", 1, 1, 0, 0, 0, 2'b00, 0, 1);
    check("R10", 16'h2345);
    // R10: same-cycle write and load uses prior value
    step("R10", 1, 1, 4'b0011, 8'h99, 0, 2'b00, 0, 1);
    check("R10", 16'h2345);
    step("R10", 1, 1, 0, 0, 0, 2'b00, 0, 1);
    check("R10", 16'h9999);

    // R9: temporary address mux
    step("R9", 1, 1, 4'b0100, 8'h3C, 0, 2'b11, 0, 0);
    step("R9", 1, 1, 4'b1000, 8'hC4, 0, 2'b11, 0, 0);
    check("R9", 16'hC43C);
    step("R9", 1, 0, 4'b1100, 8'h00, 0, 2'b11, 0, 0);
    check("R9", 16'hC43C);
    step("R9", 0, 0, 0, 0, 0, 2'b11, 0, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule